// File: doc/BRIEF.md
# Comparator-Flag Fault Diagnoser and Result Corrector

This block sits behind a duplicated-computation processing array that multiplies two N×N matrices. In that array, every result c(i,j) is produced twice, in the same cycle, by two horizontally adjacent columns. Outside comparators turn the disagreements between neighbouring columns into 2N-2 flag strings. One frame is 3N-1 beats long, and each beat carries the 2N column output words of one array cycle together with that cycle's flag bits. The block accepts one frame and studies the time shape of each flag string. From that shape it decides whether the frame saw no fault, a permanent cell fault, a transient cell fault, or a pattern that no single fault can explain. It then reports the column and the leading-zero count.

After the frame has been judged, the block sends out the N×N results as a valid/ready stream, each tagged with its i and j indices. A result whose regular column is the diagnosed column is taken from the duplicate in the column to its right instead. The duplicate slots never appear on the stream. The frame input is a valid/ready stream whose ready is high only while a frame is being collected. The result stream honours back-pressure: while `out_ready` is low, the current result is held unchanged. The diagnosis fields are plain level outputs.

Top module: `flag_fault_corrector`

## Requirements
- R1: `in_ready` is high only while a frame is being collected. Each frame is exactly 3N-1 accepted beats (11 for N=4). `in_ready` is low from the cycle after the last beat until the last result has been transferred, and it is never high together with `out_valid`.
- R2: If all 2N-2 flag strings stay zero for the whole frame, `diag_kind` is 0 (none) and `diag_col` and `diag_lead` are 0. Flag Pk is `in_flags` bit k-1.
- R3: If exactly one flag string Pk holds exactly one 1, `diag_kind` is 2 (transient), `diag_col` is k, and `diag_lead` is the number of beats before that 1.
- R4: If exactly one flag string Pk holds at least two 1s and stays 1 from its first 1 through the last beat, `diag_kind` is 1 (permanent), `diag_col` is k, and `diag_lead` is the count of leading zeros.
- R5: If the only nonzero string is P1 or P(2N-2), holds at least two 1s, and alternates 1,0,1,0 from its first 1 onward, `diag_kind` is 1 (permanent) and `diag_col` is the edge column: 0 for P1, 2N-1 for P(2N-2). `diag_lead` is the leading-zero count.
- R6: Every other pattern gives `diag_kind` 3 (uncorrectable). This covers two or more nonzero strings, where col and lead are 0, and one string of any other shape, where col is k and lead is its leading-zero count.
- R7: `diag_valid` rises in the second cycle after the last beat. It then holds, with kind, column and lead unchanged, until the first beat of the next frame is accepted.
- R8: Results leave in completion order, N×N per frame: ascending i+j, and within equal i+j, descending i. `out_i` and `out_j` are 1-based.
- R9: Result (i,j) comes from beat N-1+i+j. Its regular copy is column word N-1+j-i (`in_cols[c*W +: W]` for column c) and its duplicate is column N+j-i. The duplicate is sent when `diag_kind` is 1 or 2 and the regular column equals `diag_col`. Otherwise the regular copy is sent.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_i` and `out_j` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| in_flags | input | 2N-2 | Comparator flags P1..P(2N-2), bit k-1 is Pk |
| in_cols | input | 2N*W | Column output words, column c at bits c*W +: W |
| out_valid | output | 1 | Corrected result present |
| out_ready | input | 1 | Downstream accepts result |
| out_data | output | W | Corrected result value |
| out_i | output | clog2(N+1) | Row index i of the result |
| out_j | output | clog2(N+1) | Column index j of the result |
| diag_valid | output | 1 | Diagnosis fields hold the last frame's verdict |
| diag_kind | output | 2 | 0 none, 1 permanent, 2 transient, 3 uncorrectable |
| diag_col | output | clog2(2N) | Diagnosed column |
| diag_lead | output | clog2(3N) | Zeros before the first 1 of the flagged string |

## Verification
The bench drives the shapes that lie close to each other. These are a permanent run against a lone 1 on the same flag, a lone 1 on the last beat, alternation on an edge flag against the same alternation on an interior flag, a broken run, and two flags raised at once. A classifier that tested the run shape before the single-one shape would call a last-beat transient permanent. One that did not restrict alternation to the edge flags would accept an interior alternation instead of rejecting it. In each faulty frame the bench corrupts the regular words of the diagnosed column. A design that picked the wrong duplicate column, or mapped the wrong beat to a result, would send corrupted values. A design that reordered results, or moved them during a stall under irregular `out_ready`, would be caught on the first mismatched transfer.

// File: rtl/ffd_pkg.sv
package ffd_pkg;
  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_PERM   = 2'd1,
    KIND_TRANS  = 2'd2,
    KIND_UNCORR = 2'd3
  } fault_kind_e;

  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_JUDGE   = 2'd1,
    PH_DRAIN   = 2'd2
  } phase_e;
endpackage

// File: rtl/ffd_flag_track.sv
// Follows the time shape of one comparator flag string across a frame.
module ffd_flag_track #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_fire,
  input  logic          first_beat,
  input  logic          bit_in,
  output logic          seen,
  output logic [LW-1:0] lead,
  output logic [1:0]    ones,
  output logic          run_ok,
  output logic          alt_ok
);
  logic          expect_q;
  logic          seen_base;
  logic [LW-1:0] lead_base;

  // A new frame restarts from a cleared view of the string.
  always_comb begin
    seen_base = first_beat ? 1'b0 : seen;
    lead_base = first_beat ? '0 : lead;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      lead     <= '0;
      ones     <= '0;
      run_ok   <= 1'b0;
      alt_ok   <= 1'b0;
      expect_q <= 1'b0;
    end else if (beat_fire) begin
      if (!seen_base) begin
        if (bit_in) begin
          seen     <= 1'b1;
          lead     <= lead_base;
          ones     <= 2'd1;
          run_ok   <= 1'b1;
          alt_ok   <= 1'b1;
          expect_q <= 1'b0;
        end else begin
          seen     <= 1'b0;
          lead     <= lead_base + LW'(1);
          ones     <= 2'd0;
          run_ok   <= 1'b0;
          alt_ok   <= 1'b0;
        end
      end else begin
        if (bit_in && ones != 2'd2) ones <= ones + 2'd1;
        run_ok   <= run_ok & bit_in;
        alt_ok   <= alt_ok & (bit_in == expect_q);
        expect_q <= ~expect_q;
      end
    end
  end
endmodule

// File: rtl/ffd_classify.sv
// Maps the per-string shapes to a single-fault verdict.
module ffd_classify
  import ffd_pkg::*;
#(
  parameter int N  = 4,
  parameter int LW = 4,
  parameter int CW = 3
) (
  input  logic [2*N-3:0]        seen_v,
  input  logic [(2*N-2)*LW-1:0] lead_v,
  input  logic [(2*N-2)*2-1:0]  ones_v,
  input  logic [2*N-3:0]        run_v,
  input  logic [2*N-3:0]        alt_v,
  output fault_kind_e           kind,
  output logic [CW-1:0]         col,
  output logic [LW-1:0]         lead
);
  localparam int FLAGS = 2 * N - 2;
  localparam int COLS  = 2 * N;

  int   nseen;
  int   sel;
  logic [1:0] sel_ones;

  always_comb begin
    nseen = 0;
    sel   = 0;
    for (int k = 0; k < FLAGS; k++) begin
      if (seen_v[k]) begin
        nseen = nseen + 1;
        sel   = k;
      end
    end
    sel_ones = ones_v[sel*2 +: 2];
    kind = KIND_NONE;
    col  = '0;
    lead = '0;
    if (nseen > 1) begin
      kind = KIND_UNCORR;
    end else if (nseen == 1) begin
      lead = lead_v[sel*LW +: LW];
      col  = CW'(sel + 1);
      if (sel_ones == 2'd1) begin
        kind = KIND_TRANS;
      end else if (run_v[sel]) begin
        kind = KIND_PERM;
      end else if (alt_v[sel] && sel == 0) begin
        kind = KIND_PERM;
        col  = '0;
      end else if (alt_v[sel] && sel == FLAGS - 1) begin
        kind = KIND_PERM;
        col  = CW'(COLS - 1);
      end else begin
        kind = KIND_UNCORR;
      end
    end
  end
endmodule

// File: rtl/ffd_result_buf.sv
// Captures each result and its duplicate on its beat; reads back with correction.
module ffd_result_buf #(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int BW = 4,
  parameter int IW = 3,
  parameter int CW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_fire,
  input  logic [BW-1:0]   beat_idx,
  input  logic [2*N*W-1:0] cols,
  input  logic [IW-1:0]   rd_i,
  input  logic [IW-1:0]   rd_j,
  input  logic            fix_en,
  input  logic [CW-1:0]   fix_col,
  output logic [W-1:0]    rd_data
);
  localparam int CELLS = N * N;

  logic [W-1:0] reg_q [CELLS];
  logic [W-1:0] dup_q [CELLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CELLS; k++) begin
        reg_q[k] <= '0;
        dup_q[k] <= '0;
      end
    end else if (beat_fire) begin
      for (int i = 1; i <= N; i++) begin
        for (int j = 1; j <= N; j++) begin
          if (int'(beat_idx) == N - 1 + i + j) begin
            reg_q[(i-1)*N + (j-1)] <= cols[(N - 1 + j - i)*W +: W];
            dup_q[(i-1)*N + (j-1)] <= cols[(N + j - i)*W +: W];
          end
        end
      end
    end
  end

  int rd_idx;
  int rd_col;

  always_comb begin
    rd_idx = (int'(rd_i) - 1) * N + int'(rd_j) - 1;
    if (rd_idx < 0 || rd_idx >= CELLS) rd_idx = 0;
    rd_col = N - 1 + int'(rd_j) - int'(rd_i);
    if (fix_en && rd_col == int'(fix_col)) rd_data = dup_q[rd_idx];
    else                                   rd_data = reg_q[rd_idx];
  end
endmodule

// File: rtl/flag_fault_corrector.sv
module flag_fault_corrector
  import ffd_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [2*N-3:0]         in_flags,
  input  logic [2*N*W-1:0]       in_cols,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [W-1:0]           out_data,
  output logic [$clog2(N+1)-1:0] out_i,
  output logic [$clog2(N+1)-1:0] out_j,
  output logic                   diag_valid,
  output logic [1:0]             diag_kind,
  output logic [$clog2(2*N)-1:0] diag_col,
  output logic [$clog2(3*N)-1:0] diag_lead
);
  localparam int FLAGS = 2 * N - 2;
  localparam int COLS  = 2 * N;
  localparam int BEATS = 3 * N - 1;
  localparam int BW    = $clog2(BEATS + 1);
  localparam int LW    = $clog2(3 * N);
  localparam int CW    = $clog2(COLS);
  localparam int IW    = $clog2(N + 1);
  localparam int SW    = $clog2(2 * N + 1);

  phase_e        phase_q;
  logic [BW-1:0] beat_q;
  logic [SW-1:0] sum_q;
  logic [IW-1:0] row_q;
  logic          fire;
  logic          first_beat;

  assign fire       = in_valid && in_ready;
  assign first_beat = (int'(beat_q) == 1);
  assign in_ready   = (phase_q == PH_COLLECT);
  assign out_valid  = (phase_q == PH_DRAIN);

  logic [FLAGS-1:0]    seen_v, run_v, alt_v;
  logic [FLAGS*LW-1:0] lead_v;
  logic [FLAGS*2-1:0]  ones_v;

  for (genvar k = 0; k < FLAGS; k++) begin : g_track
    ffd_flag_track #(.LW(LW)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_fire (fire),
      .first_beat(first_beat),
      .bit_in    (in_flags[k]),
      .seen      (seen_v[k]),
      .lead      (lead_v[k*LW +: LW]),
      .ones      (ones_v[k*2 +: 2]),
      .run_ok    (run_v[k]),
      .alt_ok    (alt_v[k])
    );
  end

  fault_kind_e   cls_kind;
  logic [CW-1:0] cls_col;
  logic [LW-1:0] cls_lead;

  ffd_classify #(.N(N), .LW(LW), .CW(CW)) u_classify (
    .seen_v(seen_v),
    .lead_v(lead_v),
    .ones_v(ones_v),
    .run_v (run_v),
    .alt_v (alt_v),
    .kind  (cls_kind),
    .col   (cls_col),
    .lead  (cls_lead)
  );

  logic fix_en;
  assign fix_en = (diag_kind == KIND_PERM) || (diag_kind == KIND_TRANS);
  assign out_i  = row_q;
  assign out_j  = IW'(int'(sum_q) - int'(row_q));

  ffd_result_buf #(.N(N), .W(W), .BW(BW), .IW(IW), .CW(CW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_fire(fire),
    .beat_idx (beat_q),
    .cols     (in_cols),
    .rd_i     (out_i),
    .rd_j     (out_j),
    .fix_en   (fix_en),
    .fix_col  (diag_col),
    .rd_data  (out_data)
  );

  // Completion-order walk: next row inside the same anti-diagonal, or next diagonal.
  int            lo_row;
  logic          last_result;
  logic [SW-1:0] sum_nx;
  logic [IW-1:0] row_nx;

  always_comb begin
    lo_row      = (int'(sum_q) > N) ? int'(sum_q) - N : 1;
    last_result = (int'(sum_q) == 2 * N);
    if (int'(row_q) > lo_row) begin
      sum_nx = sum_q;
      row_nx = row_q - IW'(1);
    end else begin
      sum_nx = sum_q + SW'(1);
      row_nx = (int'(sum_q) < N) ? IW'(sum_q) : IW'(N);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_COLLECT;
      beat_q     <= BW'(1);
      sum_q      <= SW'(2);
      row_q      <= IW'(1);
      diag_valid <= 1'b0;
      diag_kind  <= KIND_NONE;
      diag_col   <= '0;
      diag_lead  <= '0;
    end else begin
      case (phase_q)
        PH_COLLECT: begin
          if (fire) begin
            if (first_beat) diag_valid <= 1'b0;
            if (int'(beat_q) == BEATS) begin
              beat_q  <= BW'(1);
              phase_q <= PH_JUDGE;
            end else begin
              beat_q <= beat_q + BW'(1);
            end
          end
        end
        PH_JUDGE: begin
          diag_valid <= 1'b1;
          diag_kind  <= cls_kind;
          diag_col   <= cls_col;
          diag_lead  <= cls_lead;
          sum_q      <= SW'(2);
          row_q      <= IW'(1);
          phase_q    <= PH_DRAIN;
        end
        PH_DRAIN: begin
          if (out_ready) begin
            if (last_result) begin
              phase_q <= PH_COLLECT;
            end else begin
              sum_q <= sum_nx;
              row_q <= row_nx;
            end
          end
        end
        default: phase_q <= PH_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/ffd_chk.sv
module ffd_chk #(
  parameter int N = 4,
  parameter int W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [W-1:0]           out_data,
  input logic [$clog2(N+1)-1:0] out_i,
  input logic [$clog2(N+1)-1:0] out_j,
  input logic                   diag_valid,
  input logic [1:0]             diag_kind,
  input logic [$clog2(2*N)-1:0] diag_col,
  input logic [$clog2(3*N)-1:0] diag_lead
);
  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_i) && $stable(out_j));

  // R7
  diag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_valid && !(in_valid && in_ready) |=> diag_valid && $stable(diag_kind)
      && $stable(diag_col) && $stable(diag_lead));

  // R7
  diag_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> diag_valid);

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_i) >= 1 && int'(out_i) <= N && int'(out_j) >= 1 && int'(out_j) <= N));

  // R2
  none_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_valid && diag_kind == 2'd0 |-> diag_col == '0 && diag_lead == '0);
endmodule

bind flag_fault_corrector ffd_chk #(.N(N), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_i     (out_i),
  .out_j     (out_j),
  .diag_valid(diag_valid),
  .diag_kind (diag_kind),
  .diag_col  (diag_col),
  .diag_lead (diag_lead)
);

// File: tb/flag_fault_corrector_tb.sv
`timescale 1ns/1ps
module flag_fault_corrector_tb;
  localparam int N = 4;
  localparam int W = 16;
  localparam int BEATS = 3 * N - 1;
  localparam int NF = 2 * N - 2;
  localparam int NC = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NF-1:0] in_flags = '0;
  logic [NC*W-1:0] in_cols = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_data;
  logic [2:0] out_i, out_j;
  logic diag_valid;
  logic [1:0] diag_kind;
  logic [2:0] diag_col;
  logic [3:0] diag_lead;

  always #2 clk = ~clk;

  flag_fault_corrector #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flags(in_flags), .in_cols(in_cols), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_i(out_i), .out_j(out_j), .diag_valid(diag_valid),
    .diag_kind(diag_kind), .diag_col(diag_col), .diag_lead(diag_lead)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;
  bit status_pending = 0;

  bit fl [1:BEATS][1:NF];
  logic [W-1:0] wd [1:BEATS][0:NC-1];
  logic [W+7:0] expq [$];
  int exp_kind, exp_col, exp_lead;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: sets out_ready, then compares each transfer against the expected queue.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      out_ready = ((cyc % 4) != 1) && ((cyc % 7) != 3);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(0, "R8 unexpected result", 0, 1);
        end else begin
          logic [W+7:0] e;
          e = expq.pop_front();
          check(out_i == e[W+7:W+4], "R8 out_i", out_i, e[W+7:W+4]);
          check(out_j == e[W+3:W], "R8 out_j", out_j, e[W+3:W]);
          check(out_data == e[W-1:0], "R9 out_data", out_data, e[W-1:0]);
        end
      end
      if (status_pending && diag_valid) begin
        status_pending = 0;
        check(diag_kind == exp_kind, "R2-R6 kind", diag_kind, exp_kind);
        check(diag_col == exp_col, "R3 col", diag_col, exp_col);
        check(diag_lead == exp_lead, "R4 lead", diag_lead, exp_lead);
      end
    end
  end

  task automatic clear_frame();
    for (int t = 1; t <= BEATS; t++) begin
      for (int k = 1; k <= NF; k++) fl[t][k] = 0;
      for (int c = 0; c < NC; c++) wd[t][c] = W'(16'hD000 + t * 16 + c);
    end
    for (int i = 1; i <= N; i++)
      for (int j = 1; j <= N; j++) begin
        wd[N-1+i+j][N-1+j-i] = W'(16'h1000 + i * 256 + j * 17);
        wd[N-1+i+j][N+j-i]   = W'(16'h1000 + i * 256 + j * 17);
      end
  endtask

  // Pattern bits: MSB is beat 1.
  task automatic put_str(input int k, input logic [BEATS-1:0] pat);
    for (int t = 1; t <= BEATS; t++) fl[t][k] = pat[BEATS - t];
  endtask

  task automatic corrupt_col(input int c);
    for (int i = 1; i <= N; i++)
      for (int j = 1; j <= N; j++)
        if (N - 1 + j - i == c) wd[N-1+i+j][c] = wd[N-1+i+j][c] ^ 16'hFFFF;
  endtask

  // Behavioural verdict from the requirement rules.
  task automatic predict();
    int nseen, sel, first, ones;
    bit allones, alt;
    nseen = 0; sel = 0;
    for (int k = 1; k <= NF; k++) begin
      bit any;
      any = 0;
      for (int t = 1; t <= BEATS; t++) if (fl[t][k]) any = 1;
      if (any) begin nseen++; sel = k; end
    end
    exp_kind = 0; exp_col = 0; exp_lead = 0;
    if (nseen > 1) exp_kind = 3;
    else if (nseen == 1) begin
      first = 0; ones = 0; allones = 1; alt = 1;
      for (int t = BEATS; t >= 1; t--) if (fl[t][sel]) first = t;
      for (int t = first; t <= BEATS; t++) begin
        if (fl[t][sel]) ones++;
        if (!fl[t][sel]) allones = 0;
        if (fl[t][sel] != (((t - first) % 2) == 0)) alt = 0;
      end
      exp_lead = first - 1;
      exp_col = sel;
      if (ones == 1) exp_kind = 2;
      else if (allones) exp_kind = 1;
      else if (alt && sel == 1) begin exp_kind = 1; exp_col = 0; end
      else if (alt && sel == NF) begin exp_kind = 1; exp_col = NC - 1; end
      else exp_kind = 3;
    end
    for (int s = 2; s <= 2 * N; s++)
      for (int i = N; i >= 1; i--) begin
        int j;
        j = s - i;
        if (j >= 1 && j <= N) begin
          logic [W-1:0] v;
          int rc;
          rc = N - 1 + j - i;
          if ((exp_kind == 1 || exp_kind == 2) && rc == exp_col) v = wd[N-1+i+j][rc+1];
          else v = wd[N-1+i+j][rc];
          expq.push_back({4'(i), 4'(j), v});
        end
      end
  endtask

  task automatic send_frame();
    predict();
    for (int t = 1; t <= BEATS; t++) begin
      in_valid = 1'b1;
      for (int k = 1; k <= NF; k++) in_flags[k-1] = fl[t][k];
      for (int c = 0; c < NC; c++) in_cols[c*W +: W] = wd[t][c];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    status_pending = 1;
    check(in_ready == 1'b0, "R1 in_ready after last beat", in_ready, 0);
    while (expq.size() != 0) @(negedge clk);
    check(diag_valid == 1'b1, "R7 diag held through drain", diag_valid, 1);
    check(status_pending == 0, "R7 diag_valid rose", status_pending, 0);
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 ready after drain", in_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0 || out_valid == 1'b0, "R1 reset exclusive", out_valid, 0);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(diag_valid == 1'b0, "R7 reset diag_valid", diag_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    // R2 clean frame
    clear_frame(); send_frame();
    // R4 interior permanent, column 3, lead 3
    clear_frame(); put_str(3, 11'b00011111111); corrupt_col(3); send_frame();
    // R3 transient on P3 at beat 5
    clear_frame(); put_str(3, 11'b00001000000); corrupt_col(3); send_frame();
    // R5 edge permanent on P1 -> column 0
    clear_frame(); put_str(1, 11'b00010101010); corrupt_col(0); send_frame();
    // R5 edge permanent on P6 -> column 7
    clear_frame(); put_str(6, 11'b00000101010); send_frame();
    // R6 two strings raised
    clear_frame(); put_str(2, 11'b00100000000); put_str(5, 11'b00000010000); corrupt_col(2); send_frame();
    // R6 broken run
    clear_frame(); put_str(2, 11'b00110111111); corrupt_col(2); send_frame();
    // R3 lone 1 on last beat counts as transient
    clear_frame(); put_str(6, 11'b00000000001); corrupt_col(6); send_frame();
    // R6 alternation on interior flag
    clear_frame(); put_str(4, 11'b00101010101); corrupt_col(4); send_frame();
    // R4 permanent in column 1, lead 1; R9 correction from column 2
    clear_frame(); put_str(1, 11'b01111111111); corrupt_col(1); send_frame();

    finished = 1;
    summary();
    $finish;
  end
endmodule